// File: doc/BRIEF.md
# Watchdog Key-Protected Register Interface with Kernel-Clock Handoff

This block is the bus-facing register file of an independent watchdog. Its configuration and command registers are written on the bus clock, and their values reach the watchdog's own kernel clock. That clock runs without any fixed phase or frequency relation to the bus. A 16-bit key register at offset 0x00 decodes magic values. One value opens write access to the four configuration registers (prescaler, reload, window, early-interrupt), one requests a counter refresh, and one starts the watchdog. Any other key closes access again.

Each configuration register has its own toggle request/acknowledge channel into the kernel domain. A per-register busy flag in the status word shows that a transfer is still in flight, and a second write to that register is refused until the flag clears. The kernel side holds the shadow copies that drive the counter core, and readback returns those shadows. An accepted window or early-interrupt write also issues a counter refresh on the kernel side. The early-warning event arrives from the kernel domain. It produces a kernel-side wake pulse and, once it has crossed back, a pending flag and a bus-clocked interrupt line.

Top module: `wdg_keyreg_cdc`

## Requirements
- R1: A write to offset 0x00 whose low 16 bits are 0x5555 opens write access to the registers at 0x04 (prescaler), 0x08 (reload), 0x10 (window) and 0x14 (early interrupt).
- R2: A key write with any other value closes write access, including 0xAAAA and 0xCCCC.
- R3: A write to a protected register while access is closed changes neither its readback nor its busy flag, and it sends nothing to the kernel domain.
- R4: After reset, reload and window read 0xFFF, prescaler and early-interrupt read 0, and status reads 0.
- R5: Status bits 0, 1, 2 and 3 are the busy flags of prescaler, reload, window and early interrupt. A flag rises on an accepted write. It clears only after the kernel-side shadow holds the new value. Readback and the kernel output then show the new value.
- R6: A write to a configuration register while its busy flag is set is discarded.
- R7: Key 0xAAAA produces one k_refresh pulse. A second 0xAAAA that arrives while the first is still crossing is dropped. Each accepted window or early-interrupt write also produces one k_refresh pulse.
- R8: Key 0xCCCC produces one k_start pulse and sets status bit 8. That bit stays set until reset.
- R9: Offset 0x00 always reads 0. Bit 14 of the early-interrupt register always reads 0. That register reads its enable in bit 15 and its threshold in bits 11:0.
- R10: k_early_evt with the kernel-side enable set gives one k_wake pulse and, later, sets status bit 14. With the enable clear it does neither.
- R11: p_irq is high when status bit 14 is set and the early-interrupt enable is set. An accepted early-interrupt write with bit 14 = 1 clears the pending flag and the interrupt. Such a write while access is closed does not clear them.
- R12: A write takes effect only if p_be[0] (low half-word) is set. A write with only p_be[1] set has no effect, and a write with only p_be[0] set is a full write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| p_clk | input | 1 | Bus clock |
| p_rst_n | input | 1 | Bus-domain reset, active low |
| p_wr | input | 1 | Write strobe, one cycle per write |
| p_addr | input | 5 | Byte offset for writes and reads |
| p_be | input | 2 | Half-word enables, bit 0 = bits 15:0 |
| p_wdata | input | 32 | Write data |
| p_rdata | output | 32 | Read data for p_addr (combinational) |
| p_irq | output | 1 | Early-warning interrupt, bus clocked |
| k_clk | input | 1 | Kernel clock |
| k_rst_n | input | 1 | Kernel-domain reset, active low |
| k_early_evt | input | 1 | Early-warning event from the counter core |
| k_start | output | 1 | One-cycle start command |
| k_refresh | output | 1 | One-cycle counter refresh command |
| k_wake | output | 1 | One-cycle wake event |
| k_presc | output | 4 | Prescaler shadow |
| k_reload | output | 12 | Reload shadow |
| k_window | output | 12 | Window shadow |
| k_ew_en | output | 1 | Early-interrupt enable shadow |
| k_ew_thr | output | 12 | Early-interrupt threshold shadow |

## Verification
The hardest situations to reach are a second request that arrives while the first one is still crossing: a rewrite of a busy register, or a second refresh key. To reach them, the bench issues the second write on the very next bus cycle. The kernel clock is set to an unrelated, slower period, so the acknowledge cannot yet have returned. It then checks that the kernel shadow holds the first value and that only one refresh pulse appeared. The pending-flag path is reached by pulsing the kernel event only after an early-interrupt enable has crossed. An acknowledge is then tried first with access closed and then with it open.

// File: rtl/wdg_regif_pkg.sv
package wdg_regif_pkg;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_KEY = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_PRE = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_RLD = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_STA = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_WIN = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_EWI = 5'h14;

    localparam logic [15:0] KEY_UNLOCK  = 16'h5555;
    localparam logic [15:0] KEY_REFRESH = 16'hAAAA;
    localparam logic [15:0] KEY_START   = 16'hCCCC;

    // channel index = status busy bit position
    localparam int CH_PRE = 0;
    localparam int CH_RLD = 1;
    localparam int CH_WIN = 2;
    localparam int CH_EWI = 3;
    localparam int NCH    = 4;

    localparam int STA_ON      = 8;
    localparam int STA_PEND    = 14;
    localparam int EWI_EN_BIT  = 15;
    localparam int EWI_ACK_BIT = 14;
endpackage

// File: rtl/wdg_sync2.sv
module wdg_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/wdg_xfer_chan.sv
module wdg_xfer_chan #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         p_clk,
    input  logic         p_rst_n,
    input  logic         p_load,
    input  logic [W-1:0] p_data,
    output logic         p_busy,
    output logic [W-1:0] p_hold,
    input  logic         k_clk,
    input  logic         k_rst_n,
    output logic [W-1:0] k_shadow,
    output logic         k_strobe
);
    typedef struct packed {
        logic         req;
        logic [W-1:0] hold;
    } bus_t;

    typedef struct packed {
        logic         seen;
        logic [W-1:0] shadow;
        logic         strobe;
    } ker_t;

    bus_t b_d, b_q;
    ker_t k_d, k_q;
    logic ack_s;
    logic req_s;

    // request toggle into kernel domain, acknowledge toggle back
    wdg_sync2 #(.W(1)) u_req_sync (.clk(k_clk), .rst_n(k_rst_n), .d(b_q.req), .q(req_s));
    wdg_sync2 #(.W(1)) u_ack_sync (.clk(p_clk), .rst_n(p_rst_n), .d(k_q.seen), .q(ack_s));

    assign p_busy   = b_q.req ^ ack_s;
    assign p_hold   = b_q.hold;
    assign k_shadow = k_q.shadow;
    assign k_strobe = k_q.strobe;

    always_comb begin
        b_d = b_q;
        if (p_load && !p_busy) begin
            b_d.req  = ~b_q.req;
            b_d.hold = p_data;
        end
    end

    always_ff @(posedge p_clk or negedge p_rst_n) begin
        if (!p_rst_n) begin
            b_q.req  <= 1'b0;
            b_q.hold <= RST_VAL;
        end else begin
            b_q <= b_d;
        end
    end

    always_comb begin
        k_d        = k_q;
        k_d.strobe = 1'b0;
        if (req_s != k_q.seen) begin
            k_d.seen   = req_s;
            k_d.shadow = b_q.hold;
            k_d.strobe = 1'b1;
        end
    end

    always_ff @(posedge k_clk or negedge k_rst_n) begin
        if (!k_rst_n) begin
            k_q.seen   <= 1'b0;
            k_q.shadow <= RST_VAL;
            k_q.strobe <= 1'b0;
        end else begin
            k_q <= k_d;
        end
    end
endmodule

// File: rtl/wdg_keyreg_cdc.sv
module wdg_keyreg_cdc
    import wdg_regif_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int PRE_W = 4
) (
    input  logic              p_clk,
    input  logic              p_rst_n,
    input  logic              p_wr,
    input  logic [ADDR_W-1:0] p_addr,
    input  logic [1:0]        p_be,
    input  logic [DATA_W-1:0] p_wdata,
    output logic [DATA_W-1:0] p_rdata,
    output logic              p_irq,
    input  logic              k_clk,
    input  logic              k_rst_n,
    input  logic              k_early_evt,
    output logic              k_start,
    output logic              k_refresh,
    output logic              k_wake,
    output logic [PRE_W-1:0]  k_presc,
    output logic [CNT_W-1:0]  k_reload,
    output logic [CNT_W-1:0]  k_window,
    output logic              k_ew_en,
    output logic [CNT_W-1:0]  k_ew_thr
);
    localparam int CW = CNT_W + 1;

    function automatic logic [CW-1:0] ch_rst(input int i);
        if (i == CH_RLD || i == CH_WIN) return CW'({CNT_W{1'b1}});
        return '0;
    endfunction

    function automatic logic [ADDR_W-1:0] ch_ofs(input int i);
        case (i)
            CH_PRE:  return OFS_PRE;
            CH_RLD:  return OFS_RLD;
            CH_WIN:  return OFS_WIN;
            default: return OFS_EWI;
        endcase
    endfunction

    typedef struct packed {
        logic unlocked;
        logic enabled;
        logic pending;
        logic irq;
        logic ev_seen;
    } bus_t;

    typedef struct packed {
        logic ev_tgl;
        logic wake;
    } ker_t;

    bus_t bq, bn;
    ker_t kq, kn;

    logic [CW-1:0]  ch_data   [NCH];
    logic [CW-1:0]  ch_hold   [NCH];
    logic [CW-1:0]  ch_shadow [NCH];
    logic [NCH-1:0] ch_load;
    logic [NCH-1:0] ch_acc;
    logic [NCH-1:0] ch_busy;
    logic [NCH-1:0] ch_strobe;

    logic wr_lo, key_wr, start_req, refr_req, ev_s;
    logic start_busy, start_hold, start_shadow, start_strobe;
    logic refr_busy, refr_hold, refr_shadow, refr_strobe;

    // observation points for the bound checker
    logic [NCH-1:0] cfg_busy;
    logic           lock_open;
    logic           wd_on;
    logic           ewi_pend;

    assign wr_lo     = p_wr && p_be[0];
    assign key_wr    = wr_lo && (p_addr == OFS_KEY);
    assign start_req = key_wr && (p_wdata[15:0] == KEY_START);
    assign refr_req  = key_wr && (p_wdata[15:0] == KEY_REFRESH);

    always_comb begin
        ch_data[CH_PRE] = CW'(p_wdata[PRE_W-1:0]);
        ch_data[CH_RLD] = CW'(p_wdata[CNT_W-1:0]);
        ch_data[CH_WIN] = CW'(p_wdata[CNT_W-1:0]);
        ch_data[CH_EWI] = {p_wdata[EWI_EN_BIT], p_wdata[CNT_W-1:0]};
        for (int i = 0; i < NCH; i++) begin
            ch_load[i] = wr_lo && (p_addr == ch_ofs(i)) && bq.unlocked;
        end
    end

    assign ch_acc = ch_load & ~ch_busy;

    for (genvar g = 0; g < NCH; g++) begin : g_cfg
        wdg_xfer_chan #(.W(CW), .RST_VAL(ch_rst(g))) u_chan (
            .p_clk    (p_clk),
            .p_rst_n  (p_rst_n),
            .p_load   (ch_load[g]),
            .p_data   (ch_data[g]),
            .p_busy   (ch_busy[g]),
            .p_hold   (ch_hold[g]),
            .k_clk    (k_clk),
            .k_rst_n  (k_rst_n),
            .k_shadow (ch_shadow[g]),
            .k_strobe (ch_strobe[g])
        );
    end

    wdg_xfer_chan #(.W(1), .RST_VAL(1'b0)) u_start_chan (
        .p_clk(p_clk), .p_rst_n(p_rst_n), .p_load(start_req), .p_data(1'b1),
        .p_busy(start_busy), .p_hold(start_hold),
        .k_clk(k_clk), .k_rst_n(k_rst_n), .k_shadow(start_shadow), .k_strobe(start_strobe)
    );

    wdg_xfer_chan #(.W(1), .RST_VAL(1'b0)) u_refr_chan (
        .p_clk(p_clk), .p_rst_n(p_rst_n), .p_load(refr_req), .p_data(1'b1),
        .p_busy(refr_busy), .p_hold(refr_hold),
        .k_clk(k_clk), .k_rst_n(k_rst_n), .k_shadow(refr_shadow), .k_strobe(refr_strobe)
    );

    // early-warning event crosses back as a toggle
    wdg_sync2 #(.W(1)) u_ev_sync (.clk(p_clk), .rst_n(p_rst_n), .d(kq.ev_tgl), .q(ev_s));

    always_comb begin
        bn = bq;
        if (key_wr) bn.unlocked = (p_wdata[15:0] == KEY_UNLOCK);
        if (start_req) bn.enabled = 1'b1;
        if (ch_acc[CH_EWI] && p_wdata[EWI_ACK_BIT]) bn.pending = 1'b0;
        if (ev_s != bq.ev_seen) begin
            bn.ev_seen = ev_s;
            bn.pending = 1'b1;
        end
        bn.irq = bq.pending && ch_hold[CH_EWI][CNT_W];
    end

    always_ff @(posedge p_clk or negedge p_rst_n) begin
        if (!p_rst_n) bq <= '0;
        else          bq <= bn;
    end

    always_comb begin
        kn      = kq;
        kn.wake = k_early_evt && ch_shadow[CH_EWI][CNT_W];
        if (kn.wake) kn.ev_tgl = ~kq.ev_tgl;
    end

    always_ff @(posedge k_clk or negedge k_rst_n) begin
        if (!k_rst_n) kq <= '0;
        else          kq <= kn;
    end

    always_comb begin
        p_rdata = '0;
        case (p_addr)
            OFS_PRE: p_rdata[PRE_W-1:0] = ch_shadow[CH_PRE][PRE_W-1:0];
            OFS_RLD: p_rdata[CNT_W-1:0] = ch_shadow[CH_RLD][CNT_W-1:0];
            OFS_WIN: p_rdata[CNT_W-1:0] = ch_shadow[CH_WIN][CNT_W-1:0];
            OFS_STA: begin
                p_rdata[NCH-1:0] = ch_busy;
                p_rdata[STA_ON]   = bq.enabled;
                p_rdata[STA_PEND] = bq.pending;
            end
            OFS_EWI: begin
                p_rdata[EWI_EN_BIT]  = ch_shadow[CH_EWI][CNT_W];
                p_rdata[CNT_W-1:0]   = ch_shadow[CH_EWI][CNT_W-1:0];
            end
            default: p_rdata = '0;
        endcase
    end

    assign p_irq     = bq.irq;
    assign k_start   = start_strobe;
    assign k_refresh = refr_strobe | ch_strobe[CH_WIN] | ch_strobe[CH_EWI];
    assign k_wake    = kq.wake;
    assign k_presc   = ch_shadow[CH_PRE][PRE_W-1:0];
    assign k_reload  = ch_shadow[CH_RLD][CNT_W-1:0];
    assign k_window  = ch_shadow[CH_WIN][CNT_W-1:0];
    assign k_ew_en   = ch_shadow[CH_EWI][CNT_W];
    assign k_ew_thr  = ch_shadow[CH_EWI][CNT_W-1:0];

    assign cfg_busy  = ch_busy;
    assign lock_open = bq.unlocked;
    assign wd_on     = bq.enabled;
    assign ewi_pend  = bq.pending;

    logic unused_bits;
    assign unused_bits = ^{p_wdata, p_be, ch_hold[CH_PRE], ch_hold[CH_RLD], ch_hold[CH_WIN],
                           ch_hold[CH_EWI][CNT_W-1:0], ch_shadow[CH_PRE], ch_strobe[CH_PRE],
                           ch_strobe[CH_RLD], start_busy, start_hold, start_shadow,
                           refr_busy, refr_hold, refr_shadow};
endmodule

// File: rtl/wdg_keyreg_cdc_chk.sv
module wdg_keyreg_cdc_chk
    import wdg_regif_pkg::*;
(
    input logic              p_clk,
    input logic              p_rst_n,
    input logic              p_wr,
    input logic [ADDR_W-1:0] p_addr,
    input logic [1:0]        p_be,
    input logic [DATA_W-1:0] p_wdata,
    input logic [DATA_W-1:0] p_rdata,
    input logic              p_irq,
    input logic              lock_open,
    input logic              wd_on,
    input logic              ewi_pend,
    input logic [NCH-1:0]    cfg_busy
);
    logic key_wr_w;
    assign key_wr_w = p_wr && p_be[0] && (p_addr == OFS_KEY);

    // R1
    unlock_key_chk: assert property (@(posedge p_clk) disable iff (!p_rst_n)
        (key_wr_w && p_wdata[15:0] == KEY_UNLOCK) |=> lock_open);

    // R2
    relock_key_chk: assert property (@(posedge p_clk) disable iff (!p_rst_n)
        (key_wr_w && p_wdata[15:0] != KEY_UNLOCK) |=> !lock_open);

    // R5
    rld_busy_rise_chk: assert property (@(posedge p_clk) disable iff (!p_rst_n)
        $rose(cfg_busy[CH_RLD]) |-> $past(p_wr && p_be[0] && p_addr == OFS_RLD && lock_open));

    // R9
    key_reads_zero_chk: assert property (@(posedge p_clk) disable iff (!p_rst_n)
        (p_addr == OFS_KEY) |-> (p_rdata == '0));

    // R8
    enable_sticky_chk: assert property (@(posedge p_clk) disable iff (!p_rst_n)
        !$fell(wd_on));

    // R11
    irq_needs_pend_chk: assert property (@(posedge p_clk) disable iff (!p_rst_n)
        p_irq |-> $past(ewi_pend));
endmodule

bind wdg_keyreg_cdc wdg_keyreg_cdc_chk u_chk (
    .p_clk     (p_clk),
    .p_rst_n   (p_rst_n),
    .p_wr      (p_wr),
    .p_addr    (p_addr),
    .p_be      (p_be),
    .p_wdata   (p_wdata),
    .p_rdata   (p_rdata),
    .p_irq     (p_irq),
    .lock_open (lock_open),
    .wd_on     (wd_on),
    .ewi_pend  (ewi_pend),
    .cfg_busy  (cfg_busy)
);

// File: tb/tb_wdg_keyreg_cdc.sv
`timescale 1ns/1ps
module tb_wdg_keyreg_cdc;
    logic        p_clk = 1'b0;
    logic        k_clk = 1'b0;
    logic        p_rst_n = 1'b0;
    logic        k_rst_n = 1'b0;
    logic        p_wr = 1'b0;
    logic [4:0]  p_addr = '0;
    logic [1:0]  p_be = '0;
    logic [31:0] p_wdata = '0;
    logic [31:0] p_rdata;
    logic        p_irq;
    logic        k_early_evt = 1'b0;
    logic        k_start, k_refresh, k_wake, k_ew_en;
    logic [3:0]  k_presc;
    logic [11:0] k_reload, k_window, k_ew_thr;

    int n_chk = 0;
    int n_fail = 0;
    int refr_cnt = 0;
    int start_cnt = 0;
    int wake_cnt = 0;
    bit done = 1'b0;

    always #10 p_clk = ~p_clk;
    always #18 k_clk = ~k_clk;

    wdg_keyreg_cdc dut (
        .p_clk(p_clk), .p_rst_n(p_rst_n), .p_wr(p_wr), .p_addr(p_addr), .p_be(p_be),
        .p_wdata(p_wdata), .p_rdata(p_rdata), .p_irq(p_irq),
        .k_clk(k_clk), .k_rst_n(k_rst_n), .k_early_evt(k_early_evt),
        .k_start(k_start), .k_refresh(k_refresh), .k_wake(k_wake),
        .k_presc(k_presc), .k_reload(k_reload), .k_window(k_window),
        .k_ew_en(k_ew_en), .k_ew_thr(k_ew_thr)
    );

    always @(negedge k_clk) begin
        if (k_refresh) refr_cnt++;
        if (k_start)   start_cnt++;
        if (k_wake)    wake_cnt++;
    end

    localparam logic [4:0]  RST_ADDR [6] = '{5'h00, 5'h04, 5'h08, 5'h0C, 5'h10, 5'h14};
    localparam logic [31:0] RST_EXP  [6] = '{32'h0, 32'h0, 32'hFFF, 32'h0, 32'hFFF, 32'h0};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [1:0] be);
        @(negedge p_clk);
        p_wr = 1'b1; p_addr = a; p_wdata = d; p_be = be;
        @(negedge p_clk);
        p_wr = 1'b0; p_be = 2'b00;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        @(negedge p_clk);
        p_addr = a;
        #1 v = p_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 200; i++) begin
            rd(5'h0C, s);
            if (s[3:0] == 4'h0) return;
        end
        check("R5 busy never cleared", s, 32'h0);
    endtask

    task automatic pulse_evt();
        @(negedge k_clk); k_early_evt = 1'b1;
        @(negedge k_clk); k_early_evt = 1'b0;
    endtask

    initial begin
        logic [31:0] v;
        int base;
        repeat (5) @(negedge p_clk);
        p_rst_n = 1'b1; k_rst_n = 1'b1;
        repeat (3) @(negedge p_clk);

        // reset values via table
        for (int i = 0; i < 6; i++) begin
            rd(RST_ADDR[i], v);
            check(i == 0 ? "R9 key reads zero" : "R4 reset value", v, RST_EXP[i]);
        end

        // R3: locked write ignored
        wr(5'h08, 32'h123, 2'b11);
        rd(5'h0C, v); check("R3 no busy when locked", v, 32'h0);
        repeat (10) @(negedge p_clk);
        rd(5'h08, v); check("R3 locked reload unchanged", v, 32'hFFF);

        // R12: unlock key in upper half only does nothing
        wr(5'h00, 32'h0000_5555, 2'b10);
        wr(5'h08, 32'h123, 2'b11);
        repeat (10) @(negedge p_clk);
        rd(5'h08, v); check("R12 upper-half key ignored", v, 32'hFFF);

        // R1/R5/R6: unlock, write reload, rewrite while busy
        wr(5'h00, 32'h5555, 2'b01);
        wr(5'h08, 32'h123, 2'b11);
        rd(5'h0C, v); check("R5 reload busy bit1", v, 32'h2);
        wr(5'h08, 32'h456, 2'b11);
        wait_idle();
        rd(5'h08, v); check("R1 R6 reload readback", v, 32'h123);
        check("R5 kernel reload", {20'h0, k_reload}, 32'h123);

        // R12: low half only is a full write; prescaler
        wr(5'h04, 32'hFFFF_0005, 2'b01);
        rd(5'h0C, v); check("R5 prescaler busy bit0", v, 32'h1);
        wait_idle();
        rd(5'h04, v); check("R12 R5 prescaler readback", v, 32'h5);

        // R7: window write refreshes
        base = refr_cnt;
        wr(5'h10, 32'h300, 2'b11);
        rd(5'h0C, v); check("R5 window busy bit2", v, 32'h4);
        wait_idle();
        repeat (4) @(negedge p_clk);
        rd(5'h10, v); check("R5 window readback", v, 32'h300);
        check("R7 window auto refresh", refr_cnt, base + 1);

        // early interrupt enable + threshold, also refreshes
        wr(5'h14, 32'h8040, 2'b11);
        rd(5'h0C, v); check("R5 early busy bit3", v, 32'h8);
        wait_idle();
        repeat (4) @(negedge p_clk);
        check("R7 early auto refresh", refr_cnt, base + 2);
        rd(5'h14, v); check("R9 early readback", v, 32'h8040);

        // R2: other key relocks
        wr(5'h00, 32'h1234, 2'b11);
        wr(5'h08, 32'h777, 2'b11);
        repeat (10) @(negedge p_clk);
        rd(5'h08, v); check("R2 relocked reload unchanged", v, 32'h123);

        // R7: double refresh back to back
        base = refr_cnt;
        wr(5'h00, 32'hAAAA, 2'b11);
        wr(5'h00, 32'hAAAA, 2'b11);
        repeat (20) @(negedge p_clk);
        check("R7 second refresh dropped", refr_cnt, base + 1);
        wr(5'h08, 32'h777, 2'b11);
        repeat (10) @(negedge p_clk);
        rd(5'h08, v); check("R2 refresh key relocks", v, 32'h123);
        wr(5'h00, 32'hAAAA, 2'b11);
        repeat (20) @(negedge p_clk);
        check("R7 later refresh", refr_cnt, base + 2);

        // R8: start
        wr(5'h00, 32'hCCCC, 2'b11);
        repeat (20) @(negedge p_clk);
        check("R8 start pulse", start_cnt, 1);
        rd(5'h0C, v); check("R8 enabled flag", v, 32'h100);
        wr(5'h00, 32'h0000, 2'b11);
        repeat (3) @(negedge p_clk);
        rd(5'h0C, v); check("R8 enabled sticky", v, 32'h100);

        // R10/R11: early event
        pulse_evt();
        repeat (12) @(negedge p_clk);
        check("R10 wake pulse", wake_cnt, 1);
        rd(5'h0C, v); check("R10 pending flag", v, 32'h4100);
        check("R11 irq high", {31'h0, p_irq}, 32'h1);

        // R11: ack while locked is ignored
        wr(5'h14, 32'hC040, 2'b11);
        repeat (10) @(negedge p_clk);
        rd(5'h0C, v); check("R11 locked ack ignored", v, 32'h4100);
        check("R11 irq stays", {31'h0, p_irq}, 32'h1);

        // R11: accepted ack clears
        wr(5'h00, 32'h5555, 2'b11);
        wr(5'h14, 32'hC040, 2'b11);
        repeat (3) @(negedge p_clk);
        check("R11 irq cleared", {31'h0, p_irq}, 32'h0);
        wait_idle();
        rd(5'h0C, v); check("R11 pending cleared", v, 32'h100);
        rd(5'h14, v); check("R9 ack bit reads zero", v, 32'h8040);

        // R10: disabled enable -> no wake, no pending
        wr(5'h14, 32'h0040, 2'b11);
        wait_idle();
        check("R10 kernel enable clear", {31'h0, k_ew_en}, 32'h0);
        pulse_evt();
        repeat (12) @(negedge p_clk);
        check("R10 no wake when disabled", wake_cnt, 1);
        rd(5'h0C, v); check("R10 no pending when disabled", v, 32'h100);
        check("R11 irq low when disabled", {31'h0, p_irq}, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge p_clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog run hung actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule